// File: doc/BRIEF.md
# Linked-Descriptor Word Feeder for a Step-Timing FIFO

This block moves 16-bit words from an internal word RAM into a downstream FIFO, usually the period queue of a step-pulse generator. It works through a chain of transfer descriptors held in a register table. A descriptor gives a starting source address and a byte count. It also has a flag that says whether the source address advances after each word, a flag that says whether to continue to another descriptor, and the index of that next descriptor. A motion profile can therefore be written as three descriptors: an acceleration table read with an advancing address, a cruise segment that repeats one stored period word many times, and a deceleration table. The processor is not involved once the chain is running.

Software fills the RAM and the descriptor table through two write ports, then pulses `start` with the index of the first descriptor. Each word moves only while the FIFO reports room (`fifo_hungry`). `busy` stays high while the chain runs. A one-clock `done` pulse marks the end of the chain.

States: IDLE (waiting for `start`), LOAD (latch the first descriptor), RUN (issue a RAM read, or move on to the next descriptor or finish), PUSH (present the word read from RAM and write it once the FIFO is hungry).

Transitions:
- IDLE→LOAD on `start`.
- LOAD→RUN when the index is valid. LOAD→IDLE when it is not.
- RUN→PUSH when words remain and `fifo_hungry` is high.
- RUN→RUN when the descriptor is used up and the chain continues. The linked descriptor is latched in the same cycle.
- RUN→IDLE when the chain ends.
- PUSH→RUN on the write.

Top module: `desc_fifo_feeder`

## Requirements
- R1: After reset, `busy`, `done` and `fifo_wr` are all low.
- R2: A descriptor with the advance flag set writes RAM words src, src+1, ... in order. Addresses wrap modulo 256.
- R3: A descriptor with the advance flag clear writes the word at src for every transfer of that descriptor.
- R4: Only bits 11:0 of `cfg_count` are stored. The number of words is bits 11:1 of that stored byte count, so each word uses 2 bytes. For example, 0x1004 gives 2 words, 5 gives 2 words, and 1 or 0 gives none.
- R5: `fifo_wr` is high only in a cycle where `fifo_hungry` is high. Exactly one word is written per such pulse.
- R6: When a descriptor is used up and its continue flag is set, the descriptor named by its link (an index below 128) is processed next. Its words follow the previous ones in the stream.
- R7: The chain ends when a used-up descriptor has its continue flag clear, or has a link of 128 or above (0xFF by convention). `busy` then falls and `done` is high for exactly one cycle, once per accepted start.
- R8: `start` while `busy` is ignored. A start index of 128 or above produces a `done` pulse and no writes.
- R9: Each word reaches `fifo_data` one clock after its RAM read is issued, which covers the RAM's single-cycle read latency. The word is held until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor table write strobe |
| cfg_idx | input | 7 | Descriptor index to write |
| cfg_src | input | 8 | Source word address |
| cfg_count | input | 16 | Requested byte count (bits 11:0 kept) |
| cfg_inc | input | 1 | Advance source address after each word |
| cfg_chain | input | 1 | Continue to the linked descriptor |
| cfg_link | input | 8 | Next descriptor index, 128 and above end the chain |
| mem_we | input | 1 | Word RAM write strobe |
| mem_waddr | input | 8 | Word RAM write address |
| mem_wdata | input | 16 | Word RAM write data |
| start | input | 1 | Begin a chain |
| start_idx | input | 8 | First descriptor index |
| fifo_hungry | input | 1 | Destination FIFO can take a word |
| fifo_wr | output | 1 | Destination write strobe |
| fifo_data | output | 16 | Destination write data |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle end-of-chain pulse |

## Verification
A wrong word counter or address register shows at the ports as a stream of the wrong length, or as a repeated or skipped word. That appears at the first write of the faulty descriptor, or at the end of the chain as a missing or extra word. A broken link decode either ends the chain early or runs on into a descriptor that should not run, so the word count differs before `done`. The random pacing of `fifo_hungry` makes a write during a not-hungry cycle, or a stale RAM word, visible within a few cycles of the stall.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
    localparam int FD_ADDR_W = 8;
    localparam int FD_CNT_W  = 12;
    localparam int FD_LINK_W = 8;

    typedef struct packed {
        logic [FD_ADDR_W-1:0] src;
        logic [FD_CNT_W-1:0]  bytes;
        logic                 inc;
        logic                 chain;
        logic [FD_LINK_W-1:0] link;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_PUSH
    } feed_st_t;
endpackage

// File: rtl/feeder_desc_table.sv
module feeder_desc_table
    import feeder_pkg::*;
#(
    parameter int NDESC = 128,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  desc_t            wdesc,
    input  logic [IDX_W-1:0] ridx_a,
    output desc_t            rdesc_a,
    input  logic [IDX_W-1:0] ridx_b,
    output desc_t            rdesc_b
);
    desc_t entries [NDESC];

    always_ff @(posedge clk) begin
        if (we) entries[widx] <= wdesc;
    end

    assign rdesc_a = entries[ridx_a];
    assign rdesc_b = entries[ridx_b];
endmodule

// File: rtl/feeder_word_ram.sv
module feeder_word_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
        if (re) rdata <= words[raddr];
    end
endmodule

// File: rtl/desc_fifo_feeder.sv
module desc_fifo_feeder
    import feeder_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NDESC  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NDESC)-1:0] cfg_idx,
    input  logic [FD_ADDR_W-1:0]     cfg_src,
    input  logic [15:0]              cfg_count,
    input  logic                     cfg_inc,
    input  logic                     cfg_chain,
    input  logic [FD_LINK_W-1:0]     cfg_link,
    input  logic                     mem_we,
    input  logic [FD_ADDR_W-1:0]     mem_waddr,
    input  logic [DATA_W-1:0]        mem_wdata,
    input  logic                     start,
    input  logic [FD_LINK_W-1:0]     start_idx,
    input  logic                     fifo_hungry,
    output logic                     fifo_wr,
    output logic [DATA_W-1:0]        fifo_data,
    output logic                     busy,
    output logic                     done
);
    localparam int IDX_W  = $clog2(NDESC);
    localparam int WORD_W = FD_CNT_W - 1;

    feed_st_t state, state_nx;

    logic [FD_LINK_W-1:0] cur_link;
    logic [FD_ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0]    words_left;
    logic                 cur_inc;
    logic                 cur_chain;
    logic [FD_LINK_W-1:0] cur_next;
    logic                 ram_re;
    logic [DATA_W-1:0]    ram_q;
    desc_t                wr_desc, first_desc, next_desc;

    function automatic logic link_ok(input logic [FD_LINK_W-1:0] l);
        return int'(l) < NDESC;
    endfunction

    function automatic logic [WORD_W-1:0] word_count(input logic [FD_CNT_W-1:0] b);
        return WORD_W'(b >> 1);
    endfunction

    always_comb begin
        wr_desc.src   = cfg_src;
        wr_desc.bytes = FD_CNT_W'(cfg_count);
        wr_desc.inc   = cfg_inc;
        wr_desc.chain = cfg_chain;
        wr_desc.link  = cfg_link;
    end

    feeder_desc_table #(.NDESC(NDESC)) table_i (
        .clk     (clk),
        .we      (cfg_we),
        .widx    (cfg_idx),
        .wdesc   (wr_desc),
        .ridx_a  (cur_link[IDX_W-1:0]),
        .rdesc_a (first_desc),
        .ridx_b  (cur_next[IDX_W-1:0]),
        .rdesc_b (next_desc)
    );

    feeder_word_ram #(.DATA_W(DATA_W), .ADDR_W(FD_ADDR_W)) ram_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (ram_re),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    logic seg_empty, go_on;
    assign seg_empty = (words_left == '0);
    assign go_on     = cur_chain && link_ok(cur_next);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOAD;
            ST_LOAD: state_nx = link_ok(cur_link) ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (seg_empty)        state_nx = go_on ? ST_RUN : ST_IDLE;
                else if (fifo_hungry) state_nx = ST_PUSH;
            end
            ST_PUSH: if (fifo_hungry) state_nx = ST_RUN;
        endcase
    end

    // state register and working descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_link   <= '0;
            rd_addr    <= '0;
            words_left <= '0;
            cur_inc    <= 1'b0;
            cur_chain  <= 1'b0;
            cur_next   <= '0;
            done       <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state != ST_IDLE) && (state_nx == ST_IDLE);
            unique case (state)
                ST_IDLE: if (start) cur_link <= start_idx;
                ST_LOAD: begin
                    rd_addr    <= first_desc.src;
                    words_left <= word_count(first_desc.bytes);
                    cur_inc    <= first_desc.inc;
                    cur_chain  <= first_desc.chain;
                    cur_next   <= first_desc.link;
                end
                ST_RUN: if (seg_empty && go_on) begin
                    rd_addr    <= next_desc.src;
                    words_left <= word_count(next_desc.bytes);
                    cur_inc    <= next_desc.inc;
                    cur_chain  <= next_desc.chain;
                    cur_next   <= next_desc.link;
                end
                ST_PUSH: if (fifo_hungry) begin
                    words_left <= words_left - 1'b1;
                    if (cur_inc) rd_addr <= rd_addr + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_re    = (state == ST_RUN) && !seg_empty && fifo_hungry;
        fifo_wr   = (state == ST_PUSH) && fifo_hungry;
        fifo_data = ram_q;
        busy      = (state != ST_IDLE);
    end
endmodule

// File: rtl/desc_fifo_feeder_chk.sv
module desc_fifo_feeder_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fifo_hungry,
    input logic fifo_wr,
    input logic busy,
    input logic done
);
    a_r5_wr_needs_hungry: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> fifo_hungry);
    a_r5_no_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fifo_wr);
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

bind desc_fifo_feeder desc_fifo_feeder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fifo_hungry (fifo_hungry),
    .fifo_wr     (fifo_wr),
    .busy        (busy),
    .done        (done)
);

// File: tb/desc_fifo_feeder_tb_top.sv
module desc_fifo_feeder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [6:0] cfg_idx = '0;
    logic [7:0] cfg_src = '0;
    logic [15:0] cfg_count = '0;
    logic cfg_inc = 1'b0, cfg_chain = 1'b0;
    logic [7:0] cfg_link = '0;
    logic mem_we = 1'b0;
    logic [7:0] mem_waddr = '0;
    logic [15:0] mem_wdata = '0;
    logic start = 1'b0;
    logic [7:0] start_idx = '0;
    logic fifo_hungry = 1'b0;
    logic fifo_wr, busy, done;
    logic [15:0] fifo_data;

    always #2 clk = ~clk;

    desc_fifo_feeder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_src(cfg_src), .cfg_count(cfg_count), .cfg_inc(cfg_inc),
        .cfg_chain(cfg_chain), .cfg_link(cfg_link), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .start(start),
        .start_idx(start_idx), .fifo_hungry(fifo_hungry), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    int done_cnt = 0, viol = 0, cycles = 0;
    bit pace_random = 1'b0;
    logic [15:0] got_q[$];
    logic [15:0] exp_q[$];

    logic [15:0] sh_mem [256];
    logic [7:0]  sh_src [128];
    logic [11:0] sh_cnt [128];
    logic        sh_inc [128];
    logic        sh_chn [128];
    logic [7:0]  sh_lnk [128];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (fifo_wr) got_q.push_back(fifo_data);
        if (fifo_wr && !fifo_hungry) viol++;
        if (done) done_cnt++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1 fifo_hungry = pace_random ? ($urandom % 4 != 0) : 1'b1;
    end

    task automatic put_desc(input int idx, input int src, input int cnt,
                            input bit inc, input bit chn, input int lnk);
        @(posedge clk); #1;
        cfg_we = 1; cfg_idx = 7'(idx); cfg_src = 8'(src); cfg_count = 16'(cnt);
        cfg_inc = inc; cfg_chain = chn; cfg_link = 8'(lnk);
        sh_src[idx] = 8'(src); sh_cnt[idx] = 12'(cnt);
        sh_inc[idx] = inc; sh_chn[idx] = chn; sh_lnk[idx] = 8'(lnk);
        @(posedge clk); #1 cfg_we = 0;
    endtask

    task automatic build_exp(input int first);
        int idx = first;
        exp_q.delete();
        for (int g = 0; g < 200 && idx < 128; g++) begin
            for (int k = 0; k < int'(sh_cnt[idx] >> 1); k++)
                exp_q.push_back(sh_mem[8'(int'(sh_src[idx]) + (sh_inc[idx] ? k : 0))]);
            if (!sh_chn[idx]) break;
            idx = int'(sh_lnk[idx]);
        end
    endtask

    task automatic run_chain(input int first, input string req, input bit poke);
        int mism = 0;
        build_exp(first);
        got_q.delete(); done_cnt = 0; viol = 0;
        @(posedge clk); #1 start = 1; start_idx = 8'(first);
        @(posedge clk); #1 start = 0;
        if (poke) begin
            repeat (3) @(posedge clk);
            #1 start = 1; start_idx = 8'd0;
            @(posedge clk); #1 start = 0;
        end
        for (int t = 0; t < 5000 && done_cnt == 0; t++) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(got_q.size() == exp_q.size(), {req, " word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] !== exp_q[i]) mism++;
        check(mism == 0, {req, " word values"}, mism, 0);
        check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        check(busy == 1'b0, "R7 busy low at end", int'(busy), 0);
        check(viol == 0, "R5 write without hungry", viol, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0 && done == 0 && fifo_wr == 0, "R1 reset outputs",
              int'({busy, done, fifo_wr}), 0);
        #1 rst_n = 1;
        for (int a = 0; a < 256; a++) begin
            @(posedge clk); #1;
            mem_we = 1; mem_waddr = 8'(a); mem_wdata = 16'($urandom);
            sh_mem[a] = mem_wdata;
        end
        @(posedge clk); #1 mem_we = 0;
        for (int i = 0; i < 128; i++) put_desc(i, 0, 0, 0, 0, 255);

        // R2 incrementing with address wrap
        put_desc(1, 250, 20, 1, 0, 255);
        run_chain(1, "R2 increment wrap", 0);
        // R3 constant word
        put_desc(2, 17, 30, 0, 0, 255);
        run_chain(2, "R3 constant word", 0);
        // R4 truncation and odd byte counts
        put_desc(3, 40, 16'h1004, 1, 1, 4);
        put_desc(4, 60, 5, 1, 1, 5);
        put_desc(5, 70, 1, 1, 0, 255);
        run_chain(3, "R4 count truncation", 0);
        // R6 three-part profile, R9 with random pacing
        pace_random = 1;
        put_desc(10, 100, 6, 1, 1, 11);
        put_desc(11, 5, 40, 0, 1, 12);
        put_desc(12, 110, 6, 1, 1, 255);
        run_chain(10, "R6 R9 profile chain", 0);
        // R7 chain flag clear stops despite valid link
        put_desc(20, 30, 4, 1, 0, 10);
        run_chain(20, "R7 chain flag clear", 0);
        // R8 start while busy ignored
        run_chain(11, "R8 start while busy", 1);
        // R8 invalid start index
        run_chain(255, "R8 invalid start 0xFF", 0);
        run_chain(128, "R8 invalid start 0x80", 0);
        // random profiles
        for (int r = 0; r < 12; r++) begin
            int d0 = 30 + ($urandom % 30);
            put_desc(d0, $urandom % 256, $urandom % 48, 1, 1, d0 + 30);
            put_desc(d0 + 30, $urandom % 256, $urandom % 48, $urandom % 2, 1, d0 + 60);
            put_desc(d0 + 60, $urandom % 256, $urandom % 48, 1, $urandom % 2,
                     ($urandom % 2) ? 255 : 200);
            run_chain(d0, "R2 R3 R6 random chain", 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule